// File: doc/BRIEF.md
# Resynchronizable 8 kHz Frame-Sync Generator

This block produces a frame-sync pulse once every 125 us frame. It runs entirely on a fast output clock. Inside that clock it keeps a phase divider that marks each period of a slower companion clock, and a frame counter that counts those slow periods through one frame. The fast-to-slow clock ratio (2 to 5) and the number of slow periods in a frame (for example 193, 256, 320, 386, 512 or 772) come in as static configuration inputs. The block does no frequency synthesis; it only counts and aligns the clocks it is given.

An external sync input can pull the frame boundary into line with a system frame. It may toggle at the frame rate, at an integer subrate of it, or be tied off. Each rising edge it presents is passed through a two-flop synchronizer and an edge detector, and then restarts both counters at zero. Between edges the counters free-run. A status output reports whether the most recent edge found the generator already in phase. The pulse can be made active high or active low. Its width is either one full slow period or half of one.

Top module: `fsync_gen`

## Requirements
- R1: While reset is held low at a clock edge, the sync output sits at its inactive level (equal to `pol_inv`) and `locked` is low. The first frame pulse starts on the first fast clock after reset is released.
- R2: Without sync edges, the pulse starts every `cfg_ratio * cfg_frame_len` fast cycles and begins at the fast cycle where both counters are zero.
- R3: With `short_sel` low, a pulse is active for exactly `cfg_ratio` fast cycles, which is one slow period.
- R4: With `short_sel` high and an even `cfg_ratio`, a pulse is active for `cfg_ratio/2` fast cycles. With `short_sel` high and an odd ratio, the pulse keeps the long width.
- R5: With `pol_inv` high, the output is active low, and it idles high between pulses.
- R6: A rising edge on `sync_in` restarts the frame. If `sync_in` is first seen high at rising clock edge k, both counters are zero from edge k+2 onward, and a pulse starts in that cycle.
- R7: A sync edge arriving every frame, or every fourth frame, keeps the pulse locked to the sync. Between edges the pulse continues to recur every frame.
- R8: Holding `sync_in` constantly high or constantly low causes no realignment, and the pulse spacing of R2 is kept.
- R9: `locked` goes high after the first sync edge following reset. After that, every sync edge sets `locked` to 1 if the edge fell on the last fast cycle of a frame (the in-phase position) and clears it to 0 otherwise.
- R10: The frame length follows `cfg_frame_len`, for any value from 2 up to 2^FRAME_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ratio | input | RATIO_W | Fast clocks per slow period, 2 to 5 |
| cfg_frame_len | input | FRAME_W | Slow periods per frame |
| short_sel | input | 1 | 1 selects the half-period pulse when the ratio is even |
| pol_inv | input | 1 | 1 makes the output active low |
| sync_in | input | 1 | Asynchronous external frame sync |
| fsync_out | output | 1 | Frame-sync pulse |
| locked | output | 1 | Latest sync edge was in phase |

## Verification
The bench keeps the default widths (RATIO_W=3, FRAME_W=10, SYNC_STAGES=2). That covers every ratio from 2 to 5 and frame lengths up to the 772-period case. Because frame length is an input, most runs use short frames of 8 to 16 slow periods, so many frame wraps, sync trains and slip events fit in a few thousand cycles. One long free-running run at length 193 checks the spacing at a realistic frame size.

// File: rtl/fsg_pkg.sv
// Package: shared limits and the pulse-width mode type for the frame-sync generator.
package fsg_pkg;
    localparam int unsigned MIN_RATIO = 2;
    localparam int unsigned MAX_RATIO = 5;

    typedef enum logic {
        PW_LONG  = 1'b0,
        PW_SHORT = 1'b1
    } pw_mode_e;
endpackage

// File: rtl/fsg_sync_detect.sv
// Synchronizes an asynchronous sync input into the fast clock domain and
// flags each rising edge with a one-cycle strobe.
// Assumes: STAGES >= 2; the input is held high for at least one fast cycle.
module fsg_sync_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the input through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    // Edge strobe: synchronized level high, previous level low.
    assign rise_o = chain[STAGES-1] & ~prev;

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/fsg_counters.sv
// Phase divider (fast cycles inside one slow period) and frame counter
// (slow periods inside one frame). Reset parks both at the frame end,
// so the first cycle after reset starts a frame. A realign request
// restarts both at zero.
// Assumes: ratio in 2..5 and frame_len >= 2, both static outside reset.
module fsg_counters #(
    parameter int RATIO_W = 3,
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [FRAME_W-1:0] frame_len,
    input  logic               realign,
    output logic [RATIO_W-1:0] phase,
    output logic [FRAME_W-1:0] frame,
    output logic               at_end
);
    localparam logic [RATIO_W-1:0] PH_ONE = RATIO_W'(1);
    localparam logic [FRAME_W-1:0] FR_ONE = FRAME_W'(1);

    logic [RATIO_W-1:0] ph_last;
    logic [FRAME_W-1:0] fr_last;

    assign ph_last = ratio - PH_ONE;
    assign fr_last = frame_len - FR_ONE;
    assign at_end  = (phase == ph_last) && (frame == fr_last);

    // Advance phase every cycle and the frame count on each phase wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ph_last;
            frame <= fr_last;
        end else if (realign) begin
            phase <= '0;
            frame <= '0;
        end else if (phase == ph_last) begin
            phase <= '0;
            frame <= (frame == fr_last) ? '0 : frame + FR_ONE;
        end else begin
            phase <= phase + PH_ONE;
        end
    end

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase < ratio);
    // R10
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame < frame_len);
    // R2
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame != $past(frame)) |-> (phase == '0));
endmodule

// File: rtl/fsg_pulse_shaper.sv
// Turns counter positions into the output pulse. The pulse is active
// during the first `width` fast cycles of slow period zero. The width is
// half a slow period when the short mode is selected and the ratio is
// even; otherwise it is a full slow period. Polarity is applied last.
// Assumes: counters come from registers, so the output is glitch-free
// relative to the fast clock.
module fsg_pulse_shaper #(
    parameter int RATIO_W = 3,
    parameter int FRAME_W = 10
) (
    input  logic               [RATIO_W-1:0] ratio,
    input  fsg_pkg::pw_mode_e                mode,
    input  logic                             pol_inv,
    input  logic               [RATIO_W-1:0] phase,
    input  logic               [FRAME_W-1:0] frame,
    output logic                             pulse_o
);
    logic [RATIO_W-1:0] width;
    logic               active;

    // Pick the pulse length in fast cycles.
    always_comb begin
        if (mode == fsg_pkg::PW_SHORT && !ratio[0]) width = ratio >> 1;
        else                                         width = ratio;
    end

    // Active window at the start of each frame, then polarity.
    assign active  = (frame == '0) && (phase < width);
    assign pulse_o = active ^ pol_inv;
endmodule

// File: rtl/fsync_gen.sv
// Top of the resynchronizable frame-sync generator. It joins the sync
// detector, the counters, the pulse shaper and the lock status tracker.
// Assumes: configuration inputs change only while reset is held.
module fsync_gen #(
    parameter int RATIO_W     = 3,
    parameter int FRAME_W     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [FRAME_W-1:0] cfg_frame_len,
    input  logic               short_sel,
    input  logic               pol_inv,
    input  logic               sync_in,
    output logic               fsync_out,
    output logic               locked
);
    logic               sync_rise;
    logic [RATIO_W-1:0] phase;
    logic [FRAME_W-1:0] frame;
    logic               at_end;
    logic               seen_sync;
    fsg_pkg::pw_mode_e  mode;

    assign mode = short_sel ? fsg_pkg::PW_SHORT : fsg_pkg::PW_LONG;

    fsg_sync_detect #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .rise_o   (sync_rise)
    );

    fsg_counters #(.RATIO_W(RATIO_W), .FRAME_W(FRAME_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio     (cfg_ratio),
        .frame_len (cfg_frame_len),
        .realign   (sync_rise),
        .phase     (phase),
        .frame     (frame),
        .at_end    (at_end)
    );

    fsg_pulse_shaper #(.RATIO_W(RATIO_W), .FRAME_W(FRAME_W)) u_shape (
        .ratio   (cfg_ratio),
        .mode    (mode),
        .pol_inv (pol_inv),
        .phase   (phase),
        .frame   (frame),
        .pulse_o (fsync_out)
    );

    // Lock status: the first edge sets it; later edges test the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_sync <= 1'b0;
            locked    <= 1'b0;
        end else if (sync_rise) begin
            seen_sync <= 1'b1;
            locked    <= !seen_sync || at_end;
        end
    end

    // R4
    ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ratio >= RATIO_W'(fsg_pkg::MIN_RATIO)) &&
        (cfg_ratio <= RATIO_W'(fsg_pkg::MAX_RATIO)));
    // R6
    realign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> (phase == '0) && (frame == '0));
    // R6
    realign_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> (fsync_out != pol_inv));
    // R9
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(sync_rise));
endmodule

// File: tb/fsync_gen_test.sv
module fsync_gen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_ratio = 3'd4;
    logic [9:0] cfg_frame_len = 10'd8;
    logic       short_sel = 1'b0;
    logic       pol_inv = 1'b0;
    logic       sync_in = 1'b0;
    wire        fsync_out;
    wire        locked;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int ph, fr, lk, seen;
    bit q[$] = '{1'b0, 1'b0, 1'b0};

    always #(CLK_PERIOD/2) clk = ~clk;

    fsync_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_ratio(cfg_ratio),
        .cfg_frame_len(cfg_frame_len), .short_sel(short_sel),
        .pol_inv(pol_inv), .sync_in(sync_in),
        .fsync_out(fsync_out), .locked(locked)
    );

    // Behavioural model advanced on each rising edge
    always @(posedge clk) begin
        int r, l;
        bit rise_m;
        r = int'(cfg_ratio);
        l = int'(cfg_frame_len);
        rise_m = (q[1] == 1'b1) && (q[2] == 1'b0);
        if (!rst_n) begin
            q = '{1'b0, 1'b0, 1'b0};
            ph = r - 1; fr = l - 1; lk = 0; seen = 0;
        end else begin
            if (rise_m) begin
                lk = (seen == 0 || (ph == r - 1 && fr == l - 1)) ? 1 : 0;
                seen = 1; ph = 0; fr = 0;
            end else if (ph == r - 1) begin
                ph = 0;
                fr = (fr == l - 1) ? 0 : fr + 1;
            end else begin
                ph = ph + 1;
            end
            q.push_front(sync_in);
            void'(q.pop_back());
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            int r, w;
            logic e_out;
            r = int'(cfg_ratio);
            w = (short_sel && (r % 2 == 0)) ? r / 2 : r;
            e_out = ((fr == 0 && ph < w) ? 1'b1 : 1'b0) ^ pol_inv;
            check_bit(rst_n ? cur_req : "R1", "fsync_out", fsync_out, e_out);
            check_bit(rst_n ? cur_req : "R1", "locked", locked, lk[0]);
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset(int r, int l, bit sh, bit pol);
        rst_n = 1'b0;
        sync_in = 1'b0;
        cfg_ratio = 3'(r);
        cfg_frame_len = 10'(l);
        short_sel = sh;
        pol_inv = pol;
        tick(3);
        chk_en = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic sync_train(int count, int period);
        for (int i = 0; i < count; i++) begin
            sync_in = 1'b1;
            tick(3);
            sync_in = 1'b0;
            tick(period - 3);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        tick(1);
        // R1 R2 R3: long pulse, realistic frame length, free run
        cur_req = "R2";
        do_reset(4, 193, 1'b0, 1'b0);
        tick(3 * 772 + 10);
        // R10: another frame length and ratio
        cur_req = "R10";
        do_reset(3, 256, 1'b0, 1'b0);
        tick(2 * 768 + 5);
        // R3: long pulse with ratio 5
        cur_req = "R3";
        do_reset(5, 8, 1'b0, 1'b0);
        tick(5 * 40);
        // R4: short pulse, even ratios, then odd ratio keeps long width
        cur_req = "R4";
        do_reset(4, 8, 1'b1, 1'b0);
        tick(5 * 32);
        do_reset(2, 12, 1'b1, 1'b0);
        tick(5 * 24);
        do_reset(3, 10, 1'b1, 1'b0);
        tick(5 * 30);
        // R5: inverted polarity, long and short
        cur_req = "R5";
        do_reset(5, 8, 1'b0, 1'b1);
        tick(4 * 40);
        do_reset(4, 8, 1'b1, 1'b1);
        tick(4 * 32);
        // R6 R9: sync at the frame rate
        cur_req = "R6";
        do_reset(4, 16, 1'b0, 1'b0);
        tick(17);
        sync_train(6, 64);
        // R7: subrate sync, one edge every fourth frame
        cur_req = "R7";
        sync_train(4, 256);
        // R9: slipped edge, then in-phase edges restore the lock
        cur_req = "R9";
        tick(100);
        sync_train(1, 64);
        sync_train(3, 64);
        // R8: sync held high, then held low
        cur_req = "R8";
        sync_in = 1'b1;
        tick(500);
        do_reset(2, 9, 1'b0, 1'b1);
        tick(400);
        chk_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule